// File: doc/BRIEF.md
# Incremental Encoder Position and Revolution Counter

This block decodes the A, B and Z signals of an incremental encoder into a wrapping position count and a revolution count, both CW bits wide. The three encoder inputs are asynchronous. Each one passes through a synchroniser chain and an edge detector that run in the system clock domain. A small mode field picks how the A and B edges turn into steps:
- independent up and down pulses;
- 4x quadrature decoding;
- a count input with a separate direction level.

Software uses one write/read register port to configure the block. Through that port it loads the counters, sets the wrap limit and the two compare values, and reads or clears the sticky event flags. The position runs from zero to a programmable maximum. Each wrap steps the revolution counter. The Z index can either clear the position or step the revolution counter.

Register map, with the offset on `addr`:
- 0, control: mode in [1:0], A edge select in [3:2], B edge select in [5:4], Z edge select in [7:6], Z action in [8].
- 1, position.
- 2, revolution.
- 3, position maximum. It resets to all ones.
- 4, position compare.
- 5, revolution compare.
- 6, flags.

Top module: `qdec_pos_rev`

## Requirements
- R1: After reset, the outputs hold these values: position 0, revolution 0, `dir_o` = 1 (up), `flags_o` = 0.
- R2: In mode 0, a selected edge of A adds one to the position and a selected edge of B subtracts one. When both occur in the same cycle, nothing changes.
- R3: In mode 1, every edge of A or B counts, whatever the edge selects say. Direction rule:
  - An A edge counts up when the new A differs from B. Otherwise it counts down.
  - A B edge counts up when the new B equals A. Otherwise it counts down.
  - When A and B both change in one cycle, nothing changes.
- R4: In mode 2, a selected A edge counts. It counts up while B is low and down while B is high. B edges alone never count. Mode 3 never counts.
- R5: Each 2-bit edge select takes one of these codes: 00 none, 01 rising, 10 falling, 11 both. An input whose select is 00 has no effect on the position.
- R6: Counting up from the maximum gives 0 and adds one to the revolution count. This sets flag bit 3. Counting down from 0 gives the maximum and subtracts one from the revolution count. This sets flag bit 4.
- R7: A selected Z edge acts according to control bit 8. When the bit is 0, the edge clears the position. When the bit is 1, the edge steps the revolution count in the current direction. A count step in the same cycle as a Z event is dropped.
- R8: Flag bit 0 is set when a count step makes the position equal to the position compare. Flag bit 1 is set when a wrap or Z step makes the revolution equal to the revolution compare.
- R9: `dir_o` gives the direction of the last count step (1 = up). Flag bit 2 is set by a step whose direction differs from the previous one.
- R10: Flags are sticky. Writing 1 to a bit at offset 6 clears that bit, and writing 0 leaves it unchanged. A flag being set in the same cycle wins over the clear.
- R11: Writes at offsets 1 and 2 load the counters. A load overrides counting in that cycle. `rd_data` returns the register selected by `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder A input (asynchronous) |
| enc_b | input | 1 | Encoder B input (asynchronous) |
| enc_z | input | 1 | Encoder index input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for write and read |
| wr_data | input | CW | Write data |
| rd_data | output | CW | Read data of the register at `addr` |
| pos_o | output | CW | Position count |
| rev_o | output | CW | Revolution count |
| dir_o | output | 1 | Last count direction, 1 = up |
| flags_o | output | 5 | Sticky flags: position match, revolution match, direction change, overflow, underflow |

## Verification
The bench builds the block with CW = 16 and a two-stage synchroniser. It programs the position maximum to 5, so that overflow and underflow wraps, both compare matches and a direction reversal all occur within a few encoder steps. Starting the revolution counter at zero and letting a Z step go downward also exercises the full 16-bit revolution wrap to 0xFFFF and back.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
   typedef enum logic [1:0] {
      CM_UPDN  = 2'd0,
      CM_PHASE = 2'd1,
      CM_DIRIN = 2'd2,
      CM_OFF   = 2'd3
   } cmode_e;

   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_POS  = 3'd1;
   localparam logic [2:0] RA_REV  = 3'd2;
   localparam logic [2:0] RA_MAX  = 3'd3;
   localparam logic [2:0] RA_CMPP = 3'd4;
   localparam logic [2:0] RA_CMPR = 3'd5;
   localparam logic [2:0] RA_FLAG = 3'd6;

   localparam int NFLAG    = 5;
   localparam int F_PMATCH = 0;
   localparam int F_RMATCH = 1;
   localparam int F_DCHG   = 2;
   localparam int F_OVF    = 3;
   localparam int F_UNF    = 4;
   localparam int CTRL_W   = 9;

   // sel: bit0 = rising edges selected, bit1 = falling edges selected
   function automatic logic edge_hit(input logic [1:0] sel, input logic r, input logic f);
      return (sel[0] & r) | (sel[1] & f);
   endfunction
endpackage

// File: rtl/qdec_sync_edge.sv
module qdec_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdec_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   // R5: a detected rising edge is a real low-to-high move of the synchronised level
   p_rise_is_rose_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> $rose(lvl));
endmodule

// File: rtl/qdec_step.sv
module qdec_step
   import qdec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cmode_e     mode,
   input  logic [1:0] sel_a,
   input  logic [1:0] sel_b,
   input  logic       a_lvl,
   input  logic       b_lvl,
   input  logic       a_r,
   input  logic       a_f,
   input  logic       b_r,
   input  logic       b_f,
   output logic       up,
   output logic       dn
);
   logic a_ev, b_ev, a_any, b_any, differ;

   always_comb begin
      a_ev   = edge_hit(sel_a, a_r, a_f);
      b_ev   = edge_hit(sel_b, b_r, b_f);
      a_any  = a_r | a_f;
      b_any  = b_r | b_f;
      differ = a_lvl ^ b_lvl;
      up     = 1'b0;
      dn     = 1'b0;
      unique case (mode)
         CM_UPDN: begin
            up = a_ev & ~b_ev;
            dn = b_ev & ~a_ev;
         end
         CM_PHASE: begin
            if (a_any && !b_any) begin
               up = differ;
               dn = ~differ;
            end else if (b_any && !a_any) begin
               up = ~differ;
               dn = differ;
            end
         end
         CM_DIRIN: begin
            up = a_ev & ~b_lvl;
            dn = a_ev & b_lvl;
         end
         default: begin
            up = 1'b0;
            dn = 1'b0;
         end
      endcase
   end

   // R3: never a step in both directions at once
   p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({up, dn}));
endmodule

// File: rtl/qdec_pos_rev.sv
module qdec_pos_rev
   import qdec_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_z,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [CW-1:0]    wr_data,
   output logic [CW-1:0]    rd_data,
   output logic [CW-1:0]    pos_o,
   output logic [CW-1:0]    rev_o,
   output logic             dir_o,
   output logic [NFLAG-1:0] flags_o
);
   localparam int NIN = 3;

   generate
      if (CW < CTRL_W) begin : g_bad_cw
         $error("qdec_pos_rev: CW must hold the control register");
      end
   endgenerate

   logic [NIN-1:0] in_raw, lvl, rise, fall;
   assign in_raw = {enc_z, enc_b, enc_a};

   generate
      for (genvar g = 0; g < NIN; g++) begin : g_in
         qdec_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
            .clk (clk), .rst_n(rst_n), .din(in_raw[g]),
            .lvl (lvl[g]), .rise(rise[g]), .fall(fall[g])
         );
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [CW-1:0]     pos_q, rev_q, max_q, cmpp_q, cmpr_q, pos_d, rev_d;
   logic [NFLAG-1:0]  flags_q, flags_d, set_m, clr_m;
   logic              dir_q, dir_d;
   logic              st_up, st_dn;
   cmode_e            mode;

   assign mode = cmode_e'(ctrl_q[1:0]);

   qdec_step u_step (
      .clk  (clk), .rst_n(rst_n), .mode(mode),
      .sel_a(ctrl_q[3:2]), .sel_b(ctrl_q[5:4]),
      .a_lvl(lvl[0]), .b_lvl(lvl[1]),
      .a_r  (rise[0]), .a_f(fall[0]), .b_r(rise[1]), .b_f(fall[1]),
      .up   (st_up), .dn(st_dn)
   );

   logic wr_ctrl, wr_pos, wr_rev, wr_max, wr_cmpp, wr_cmpr, wr_flag;
   logic z_ev, z_rev, cnt_eff, at_max, at_zero, wrap_up, wrap_dn;
   logic rev_inc, rev_dec, rev_chg;

   always_comb begin
      wr_ctrl = wr_en && (addr == RA_CTRL);
      wr_pos  = wr_en && (addr == RA_POS);
      wr_rev  = wr_en && (addr == RA_REV);
      wr_max  = wr_en && (addr == RA_MAX);
      wr_cmpp = wr_en && (addr == RA_CMPP);
      wr_cmpr = wr_en && (addr == RA_CMPR);
      wr_flag = wr_en && (addr == RA_FLAG);

      z_ev    = edge_hit(ctrl_q[7:6], rise[2], fall[2]);
      z_rev   = ctrl_q[8];
      cnt_eff = (st_up | st_dn) && !z_ev && !wr_pos;
      at_max  = (pos_q == max_q);
      at_zero = (pos_q == '0);
      wrap_up = cnt_eff && st_up && at_max;
      wrap_dn = cnt_eff && st_dn && at_zero;

      pos_d = pos_q;
      if (wr_pos)              pos_d = wr_data;
      else if (z_ev && !z_rev) pos_d = '0;
      else if (cnt_eff) begin
         if (st_up) pos_d = at_max  ? '0    : pos_q + 1'b1;
         else       pos_d = at_zero ? max_q : pos_q - 1'b1;
      end

      rev_inc = (z_ev && z_rev && dir_q)  || wrap_up;
      rev_dec = (z_ev && z_rev && !dir_q) || wrap_dn;
      rev_chg = !wr_rev && (rev_inc || rev_dec);
      rev_d   = rev_q;
      if (wr_rev)       rev_d = wr_data;
      else if (rev_inc) rev_d = rev_q + 1'b1;
      else if (rev_dec) rev_d = rev_q - 1'b1;

      dir_d = cnt_eff ? st_up : dir_q;

      set_m           = '0;
      set_m[F_PMATCH] = cnt_eff && (pos_d == cmpp_q);
      set_m[F_RMATCH] = rev_chg && (rev_d == cmpr_q);
      set_m[F_DCHG]   = cnt_eff && (st_up != dir_q);
      set_m[F_OVF]    = wrap_up;
      set_m[F_UNF]    = wrap_dn;
      clr_m           = wr_flag ? wr_data[NFLAG-1:0] : '0;
      flags_d         = (flags_q & ~clr_m) | set_m;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         pos_q   <= '0;
         rev_q   <= '0;
         max_q   <= '1;
         cmpp_q  <= '0;
         cmpr_q  <= '0;
         flags_q <= '0;
         dir_q   <= 1'b1;
      end else begin
         if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
         if (wr_max)  max_q  <= wr_data;
         if (wr_cmpp) cmpp_q <= wr_data;
         if (wr_cmpr) cmpr_q <= wr_data;
         pos_q   <= pos_d;
         rev_q   <= rev_d;
         dir_q   <= dir_d;
         flags_q <= flags_d;
      end
   end

   always_comb begin
      unique case (addr)
         RA_CTRL: rd_data = CW'(ctrl_q);
         RA_POS:  rd_data = pos_q;
         RA_REV:  rd_data = rev_q;
         RA_MAX:  rd_data = max_q;
         RA_CMPP: rd_data = cmpp_q;
         RA_CMPR: rd_data = cmpr_q;
         RA_FLAG: rd_data = CW'(flags_q);
         default: rd_data = '0;
      endcase
   end

   assign pos_o   = pos_q;
   assign rev_o   = rev_q;
   assign dir_o   = dir_q;
   assign flags_o = flags_q;

   // R9: an upward step leaves the direction status at up
   p_dir_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_eff && st_up) |=> dir_o);

   // R7: a clearing Z event without a load leaves position zero
   p_zclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (z_ev && !z_rev && !wr_pos) |=> (pos_o == '0));

   // R6: upward wrap returns to zero and bumps the revolution count
   p_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_up && !wr_rev) |=> (pos_o == '0) && (rev_o == $past(rev_o) + 1'b1));

   // R10: a set flag only drops when a write-one-clear names it
   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flags_o) & ~$past(clr_m)) & ~flags_o) == '0));
endmodule

// File: tb/qdec_pos_rev_tb_top.sv
`timescale 1ns/1ps
module qdec_pos_rev_tb_top;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] rd_data, pos_o, rev_o;
   logic          dir_o;
   logic [4:0]    flags_o;

   always #2.5 clk = ~clk;

   qdec_pos_rev #(.CW(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .pos_o(pos_o), .rev_o(rev_o), .dir_o(dir_o), .flags_o(flags_o)
   );

   typedef struct {
      logic [CW-1:0] p;
      logic [CW-1:0] r;
      string         tag;
   } exp_t;

   exp_t sbq[$];
   int   total = 0;
   int   bad   = 0;
   bit   done  = 0;

   task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // driver: apply encoder levels, let them pass sync + edge stage, push expectation
   task automatic drive(input logic a, input logic b, input logic z,
                        input logic [CW-1:0] ep, input logic [CW-1:0] er, input string tag);
      @(negedge clk);
      enc_a = a; enc_b = b; enc_z = z;
      repeat (4) @(posedge clk);
      @(negedge clk);
      sbq.push_back('{ep, er, tag});
   endtask

   task automatic wreg(input logic [2:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // monitor: pop and compare away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk({e.tag, " pos"}, pos_o, e.p);
            chk({e.tag, " rev"}, rev_o, e.r);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 reset pos", pos_o, 0);
      chk("R1 reset rev", rev_o, 0);
      chk("R1 reset dir", CW'(dir_o), 1);
      chk("R1 reset flags", CW'(flags_o), 0);

      // mode 0, A rising, B rising
      wreg(3'd0, 16'h0014);
      drive(1, 0, 0, 1, 0, "R2 A rise up");
      drive(0, 0, 0, 1, 0, "R5 A fall ignored");
      drive(1, 0, 0, 2, 0, "R2 A rise up");
      drive(0, 0, 0, 2, 0, "R2 idle");
      drive(0, 1, 0, 1, 0, "R2 B rise down");
      drive(0, 0, 0, 1, 0, "R2 idle");
      drive(1, 1, 0, 1, 0, "R2 both cancel");
      drive(0, 0, 0, 1, 0, "R2 idle");
      wreg(3'd0, 16'h001C);
      drive(1, 0, 0, 2, 0, "R5 both-edge rise");
      drive(0, 0, 0, 3, 0, "R5 both-edge fall");
      wreg(3'd0, 16'h0010);
      drive(1, 0, 0, 3, 0, "R5 A none");
      drive(0, 0, 0, 3, 0, "R5 A none");
      #1;
      chk("R9 dir after up", CW'(dir_o), 1);
      chk("R9 dir change flag", CW'(flags_o), 16'h04);
      wreg(3'd6, 16'h001F);
      #1;
      chk("R10 clear all", CW'(flags_o), 0);

      // mode 1 quadrature, max 5, compares 2 and 1
      wreg(3'd0, 16'h0001);
      wreg(3'd3, 16'd5);
      wreg(3'd4, 16'd2);
      wreg(3'd5, 16'd1);
      wreg(3'd1, 16'd0);
      drive(1, 0, 0, 1, 0, "R3 A lead 1");
      drive(1, 1, 0, 2, 0, "R3 A lead 2");
      drive(0, 1, 0, 3, 0, "R3 A lead 3");
      drive(0, 0, 0, 4, 0, "R3 A lead 4");
      drive(1, 0, 0, 5, 0, "R3 A lead 5");
      drive(1, 1, 0, 0, 1, "R6 overflow wrap");
      drive(1, 0, 0, 5, 0, "R6 underflow wrap");
      #1;
      chk("R8 R6 R9 flags", CW'(flags_o), 16'h1F);
      chk("R9 dir down", CW'(dir_o), 0);
      drive(0, 1, 0, 5, 0, "R3 double change");
      drive(1, 1, 0, 4, 0, "R3 B lead down");
      drive(0, 0, 0, 4, 0, "R3 double change");
      wreg(3'd6, 16'h0000);
      #1;
      chk("R10 write zero keeps", CW'(flags_o), 16'h1F);
      wreg(3'd6, 16'h001F);
      #1;
      chk("R10 write ones clears", CW'(flags_o), 0);

      // mode 2 count with direction level
      wreg(3'd0, 16'h0006);
      wreg(3'd1, 16'd2);
      drive(1, 0, 0, 3, 0, "R4 B low up");
      drive(0, 0, 0, 3, 0, "R4 idle");
      drive(0, 1, 0, 3, 0, "R4 B edge no count");
      drive(1, 1, 0, 2, 0, "R4 B high down");
      drive(0, 1, 0, 2, 0, "R4 idle");
      drive(0, 0, 0, 2, 0, "R4 B edge no count");
      #1;
      chk("R8 R9 flags", CW'(flags_o), 16'h05);

      // Z handling
      wreg(3'd0, 16'h0046);
      drive(0, 0, 1, 0, 0, "R7 Z clears");
      drive(0, 0, 0, 0, 0, "R7 idle");
      wreg(3'd0, 16'h0146);
      drive(0, 0, 1, 0, 16'hFFFF, "R7 Z rev down");
      drive(0, 0, 0, 0, 16'hFFFF, "R7 idle");
      drive(1, 0, 0, 1, 16'hFFFF, "R4 up again");
      drive(0, 0, 0, 1, 16'hFFFF, "R7 idle");
      drive(1, 0, 1, 1, 0, "R7 Z wins over count");
      drive(0, 0, 0, 1, 0, "R7 idle");

      @(negedge clk);
      addr = 3'd1;
      #1;
      chk("R11 read position", rd_data, 16'd1);
      addr = 3'd3;
      #1;
      chk("R11 read max", rd_data, 16'd5);
      wreg(3'd2, 16'h0042);
      #1;
      chk("R11 load rev", rev_o, 16'h0042);

      repeat (3) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule